// File: doc/BRIEF.md
# Private Peripheral Window Decoder

The block sits between a register bus and the private peripherals of a cluster of up to four processors. Each access carries a 12-bit window offset and the index of the processor that issued it. The decoder sends it to one of three places. The first is a small local group of cluster-control registers. The second is the interrupt-controller CPU interface of one processor. The third is one of two timer instances (general timer or watchdog) of one processor.

Two kinds of window lead to the interrupt interface and to the timers. An alias window always reaches the requesting processor's own instance. Explicit windows are indexed by processor number. Local reads are answered by the decoder itself. Reads from the interrupt interface and the timers are taken from their data inputs in the request cycle. Every response comes back exactly one cycle after the request. The block also routes each timer's interrupt line to the correct private-interrupt bit of its owning processor.

Top module: `priv_window_decoder`

## Requirements
- R1: Only address bits [11:0] take part in decoding. Accesses that differ only above bit 11 behave identically.
- R2: Offset 0x000 is the cluster-control register. A write stores wdata bit 0 and discards the rest. A read returns the stored bit in bit 0 with zeros above it.
- R3: Offset 0x004 reads 0x000000F3, offset 0x008 reads 0, and offset 0x00C reads 0. A write to 0x00C is accepted without error and changes no state.
- R4: In 0x000–0x0FF, rsp_err_o is 1 in the response cycle for a read at any offset other than 0x00, 0x04, 0x08 and 0x0C. It is also 1 for a write at any offset other than 0x00 and 0x0C. In every other case it is 0.
- R5: Offsets 0x100–0x1FF assert gic_sel_o in the request cycle, with gic_cpu_o equal to the requester and gic_off_o equal to addr[7:0].
- R6: Offsets 0x200–0x5FF assert gic_sel_o with gic_cpu_o = (offset − 0x200) >> 8 and gic_off_o = addr[7:0].
- R7: Offsets 0x600–0x6FF assert tmr_sel_o for the requester. tmr_idx_o = cpu × 2 + addr[5], where bit 0 set means the watchdog, and tmr_off_o = addr[3:0].
- R8: Offsets 0x700–0xAFF assert tmr_sel_o for cpu = (offset − 0x700) >> 8, with the same index and offset rule as R7.
- R9: Offsets 0xB00–0xFFF, and any window whose target processor is NCPU or higher, select nothing, read 0 and raise no error.
- R10: rsp_valid_o is 1 exactly one cycle after each request cycle. In that cycle rsp_rdata_o carries the target's read data sampled in the request cycle, and it carries 0 for writes. Back-to-back requests are supported.
- R11: Bit c·32+29 of ppi_o follows tmr_irq_i[2c], bit c·32+30 follows tmr_irq_i[2c+1], and every other bit of ppi_o is 0.
- R12: While rst_ni is low, rsp_valid_o, rsp_err_o and rsp_rdata_o are 0 and the control bit clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address (low 12 bits decoded) |
| req_wdata_i | input | 32 | Write data |
| req_cpu_i | input | 2 | Index of requesting processor |
| rsp_valid_o | output | 1 | Response cycle marker |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Bad control-group access |
| gic_sel_o | output | 1 | Interrupt CPU interface selected |
| gic_cpu_o | output | 2 | Target processor of interface access |
| gic_off_o | output | 8 | Local offset within interface |
| gic_rdata_i | input | 32 | Interface read data, same cycle |
| tmr_sel_o | output | 1 | Timer instance selected |
| tmr_idx_o | output | 3 | Timer instance index |
| tmr_off_o | output | 4 | Local offset within timer |
| tmr_rdata_i | input | 32 | Timer read data, same cycle |
| tgt_write_o | output | 1 | Write strobe qualifier for targets |
| tgt_wdata_o | output | 32 | Write data to targets |
| tmr_irq_i | input | 2*NCPU | Timer interrupt lines, two per processor |
| ppi_o | output | 32*NCPU | Private interrupt vector per processor |

## Verification
The bench builds the decoder with NCPU = 3 rather than the default 4. The fourth slot of each explicit window then lands on a processor that does not exist, which makes the out-of-range suppression of R9 observable through the selects, the read data and the error flag. The interrupt and timer read-data inputs are driven from the forwarded processor and offset, so every read response shows whether routing was correct. With three processors, tmr_irq_i also has six lines, which covers routing for a non-power-of-two count.

// File: rtl/priv_win_pkg.sv
package priv_win_pkg;
  localparam int MAX_CPU   = 4;
  localparam int CPU_W     = 2;
  localparam int OFF_W     = 12;
  localparam int DATA_W    = 32;
  localparam int GIC_OFF_W = 8;
  localparam int TMR_OFF_W = 4;
  localparam int TMR_IDX_W = CPU_W + 1;
  localparam int PPI_W     = 32;
  localparam int TMR_SEL_BIT = 5;

  // 256-byte slot numbers inside the window
  localparam logic [3:0] SLOT_CTRL      = 4'd0;
  localparam logic [3:0] SLOT_GIC_SELF  = 4'd1;
  localparam logic [3:0] SLOT_GIC_FIRST = 4'd2;
  localparam logic [3:0] SLOT_GIC_LAST  = 4'd5;
  localparam logic [3:0] SLOT_TMR_SELF  = 4'd6;
  localparam logic [3:0] SLOT_TMR_FIRST = 4'd7;
  localparam logic [3:0] SLOT_TMR_LAST  = 4'd10;

  localparam logic [7:0] CR_CTRL  = 8'h00;
  localparam logic [7:0] CR_CFG   = 8'h04;
  localparam logic [7:0] CR_STAT  = 8'h08;
  localparam logic [7:0] CR_INVAL = 8'h0C;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CTRL = 2'd1,
    TGT_GIC  = 2'd2,
    TGT_TMR  = 2'd3
  } tgt_e;
endpackage

// File: rtl/pw_region_decode.sv
module pw_region_decode
  import priv_win_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [CPU_W-1:0] req_cpu_i,
  output tgt_e             tgt_o,
  output logic [CPU_W-1:0] cpu_o
);
  logic [3:0]       slot;
  tgt_e             tgt_raw;
  logic [CPU_W-1:0] cpu_raw;

  assign slot = off_i[OFF_W-1:8];

  always_comb begin
    tgt_raw = TGT_NONE;
    cpu_raw = '0;
    if (slot == SLOT_CTRL) begin
      tgt_raw = TGT_CTRL;
    end else if (slot == SLOT_GIC_SELF) begin
      tgt_raw = TGT_GIC;
      cpu_raw = req_cpu_i;
    end else if (slot >= SLOT_GIC_FIRST && slot <= SLOT_GIC_LAST) begin
      tgt_raw = TGT_GIC;
      cpu_raw = CPU_W'(slot - SLOT_GIC_FIRST);
    end else if (slot == SLOT_TMR_SELF) begin
      tgt_raw = TGT_TMR;
      cpu_raw = req_cpu_i;
    end else if (slot >= SLOT_TMR_FIRST && slot <= SLOT_TMR_LAST) begin
      tgt_raw = TGT_TMR;
      cpu_raw = CPU_W'(slot - SLOT_TMR_FIRST);
    end
  end

  // processors beyond NCPU do not exist: drop the access
  always_comb begin
    tgt_o = tgt_raw;
    cpu_o = cpu_raw;
    if ((tgt_raw == TGT_GIC || tgt_raw == TGT_TMR) && int'(cpu_raw) >= NCPU) begin
      tgt_o = TGT_NONE;
      cpu_o = '0;
    end
  end
endmodule

// File: rtl/pw_ctrl_regs.sv
module pw_ctrl_regs
  import priv_win_pkg::*;
#(
  parameter logic [DATA_W-1:0] CFG_VAL = 32'h0000_00F3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              write_i,
  input  logic [7:0]        off_i,
  input  logic              wbit_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  logic ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ctrl_q <= 1'b0;
    else if (sel_i && write_i && off_i == CR_CTRL) ctrl_q <= wbit_i;
  end

  always_comb begin
    rdata_o = '0;
    err_o   = 1'b0;
    if (write_i) begin
      err_o = sel_i && (off_i != CR_CTRL) && (off_i != CR_INVAL);
    end else begin
      unique case (off_i)
        CR_CTRL:  rdata_o = {{(DATA_W-1){1'b0}}, ctrl_q};
        CR_CFG:   rdata_o = CFG_VAL;
        CR_STAT:  rdata_o = '0;
        CR_INVAL: rdata_o = '0;
        default:  err_o   = sel_i;
      endcase
    end
  end
endmodule

// File: rtl/pw_tmr_irq_route.sv
module pw_tmr_irq_route
  import priv_win_pkg::*;
#(
  parameter int NCPU       = 4,
  parameter int TMR_PPI_ID = 29
) (
  input  logic [2*NCPU-1:0]     tmr_irq_i,
  output logic [PPI_W*NCPU-1:0] ppi_o
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    always_comb begin
      ppi_o[c*PPI_W +: PPI_W]          = '0;
      ppi_o[c*PPI_W + TMR_PPI_ID]      = tmr_irq_i[2*c];
      ppi_o[c*PPI_W + TMR_PPI_ID + 1]  = tmr_irq_i[2*c+1];
    end
  end
endmodule

// File: rtl/priv_window_decoder.sv
module priv_window_decoder
  import priv_win_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NCPU   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic                     req_write_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [31:0]              req_wdata_i,
  input  logic [1:0]               req_cpu_i,
  output logic                     rsp_valid_o,
  output logic [31:0]              rsp_rdata_o,
  output logic                     rsp_err_o,
  output logic                     gic_sel_o,
  output logic [1:0]               gic_cpu_o,
  output logic [7:0]               gic_off_o,
  input  logic [31:0]              gic_rdata_i,
  output logic                     tmr_sel_o,
  output logic [2:0]               tmr_idx_o,
  output logic [3:0]               tmr_off_o,
  input  logic [31:0]              tmr_rdata_i,
  output logic                     tgt_write_o,
  output logic [31:0]              tgt_wdata_o,
  input  logic [2*NCPU-1:0]        tmr_irq_i,
  output logic [32*NCPU-1:0]       ppi_o
);
  logic [OFF_W-1:0]  off;
  logic              unused_addr_hi;
  tgt_e              tgt;
  logic [CPU_W-1:0]  tcpu;
  logic [DATA_W-1:0] ctrl_rdata, rdata_d;
  logic              ctrl_err;

  assign off            = req_addr_i[OFF_W-1:0];
  assign unused_addr_hi = ^req_addr_i[ADDR_W-1:OFF_W];

  pw_region_decode #(.NCPU(NCPU)) u_dec (
    .off_i     (off),
    .req_cpu_i (req_cpu_i),
    .tgt_o     (tgt),
    .cpu_o     (tcpu)
  );

  pw_ctrl_regs u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (req_valid_i && tgt == TGT_CTRL),
    .write_i (req_write_i),
    .off_i   (off[7:0]),
    .wbit_i  (req_wdata_i[0]),
    .rdata_o (ctrl_rdata),
    .err_o   (ctrl_err)
  );

  pw_tmr_irq_route #(.NCPU(NCPU)) u_irq (
    .tmr_irq_i (tmr_irq_i),
    .ppi_o     (ppi_o)
  );

  assign gic_sel_o   = req_valid_i && tgt == TGT_GIC;
  assign gic_cpu_o   = tcpu;
  assign gic_off_o   = off[GIC_OFF_W-1:0];
  assign tmr_sel_o   = req_valid_i && tgt == TGT_TMR;
  assign tmr_idx_o   = {tcpu, off[TMR_SEL_BIT]};
  assign tmr_off_o   = off[TMR_OFF_W-1:0];
  assign tgt_write_o = req_write_i;
  assign tgt_wdata_o = req_wdata_i;

  always_comb begin
    rdata_d = '0;
    if (!req_write_i) begin
      unique case (tgt)
        TGT_CTRL: rdata_d = ctrl_rdata;
        TGT_GIC:  rdata_d = gic_rdata_i;
        TGT_TMR:  rdata_d = tmr_rdata_i;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= req_valid_i ? rdata_d : '0;
      rsp_err_o   <= req_valid_i && ctrl_err;
    end
  end
endmodule

// File: rtl/priv_window_decoder_chk.sv
module priv_window_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int NCPU   = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_write_i,
  input logic [ADDR_W-1:0]   req_addr_i,
  input logic [1:0]          req_cpu_i,
  input logic                rsp_valid_o,
  input logic [31:0]         rsp_rdata_o,
  input logic                rsp_err_o,
  input logic                gic_sel_o,
  input logic [1:0]          gic_cpu_o,
  input logic                tmr_sel_o,
  input logic [2:0]          tmr_idx_o,
  input logic [2*NCPU-1:0]   tmr_irq_i,
  input logic [32*NCPU-1:0]  ppi_o
);
  a_r10_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r10_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r4_err_in_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_valid_o);
  a_r4_err_only_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[11:8] != 4'd0) |=> !rsp_err_o);
  a_r10_write_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> rsp_rdata_o == 32'd0);
  a_r9_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gic_sel_o && tmr_sel_o));
  a_r5_alias_gic_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gic_sel_o && req_addr_i[11:8] == 4'd1) |-> gic_cpu_o == req_cpu_i);
  a_r7_wdog_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_sel_o |-> tmr_idx_o[0] == req_addr_i[5]);
  a_r9_high_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_addr_i[11:8] > 4'd10) |-> !(gic_sel_o || tmr_sel_o));
  a_r11_cpu0_timer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppi_o[29] == tmr_irq_i[0] && ppi_o[30] == tmr_irq_i[1] && ppi_o[28:0] == '0);
endmodule

bind priv_window_decoder priv_window_decoder_chk #(.ADDR_W(ADDR_W), .NCPU(NCPU)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_cpu_i   (req_cpu_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .rsp_err_o   (rsp_err_o),
  .gic_sel_o   (gic_sel_o),
  .gic_cpu_o   (gic_cpu_o),
  .tmr_sel_o   (tmr_sel_o),
  .tmr_idx_o   (tmr_idx_o),
  .tmr_irq_i   (tmr_irq_i),
  .ppi_o       (ppi_o)
);

// File: tb/tb_priv_window_decoder.sv
module tb_priv_window_decoder;
  localparam int NCPU = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [31:0]       req_addr_i = '0, req_wdata_i = '0;
  logic [1:0]        req_cpu_i = '0;
  logic              rsp_valid_o, rsp_err_o, gic_sel_o, tmr_sel_o, tgt_write_o;
  logic [31:0]       rsp_rdata_o, gic_rdata_i, tmr_rdata_i, tgt_wdata_o;
  logic [1:0]        gic_cpu_o;
  logic [7:0]        gic_off_o;
  logic [2:0]        tmr_idx_o;
  logic [3:0]        tmr_off_o;
  logic [2*NCPU-1:0] tmr_irq_i = '0;
  logic [32*NCPU-1:0] ppi_o;

  int n_run = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  // targets echo what they were asked for, so routing shows in the data
  assign gic_rdata_i = {16'hA11C, 6'd0, gic_cpu_o, gic_off_o};
  assign tmr_rdata_i = {16'hB7E0, 9'd0, tmr_idx_o, tmr_off_o};

  priv_window_decoder #(.ADDR_W(32), .NCPU(NCPU)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  cpu;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [1:0]  sel;    // 0 none, 1 ctrl, 2 interrupt interface, 3 timer
    logic [1:0]  tcpu;
    logic [7:0]  loc;    // gic offset, or {idx,off} for timers
    logic [31:0] rdata;
    logic        err;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS[NV] = '{
    '{1'b1, 2'd0, 32'h0000_0000, 32'hFFFF_FFFF, 2'd1, 2'd0, 8'h00, 32'h0000_0000, 1'b0}, // R2 write
    '{1'b0, 2'd0, 32'h0000_0000, 32'h0,         2'd1, 2'd0, 8'h00, 32'h0000_0001, 1'b0}, // R2 read 1
    '{1'b1, 2'd1, 32'h0000_000C, 32'h0,         2'd1, 2'd0, 8'h00, 32'h0000_0000, 1'b0}, // R3 inval write
    '{1'b0, 2'd0, 32'h0000_0000, 32'h0,         2'd1, 2'd0, 8'h00, 32'h0000_0001, 1'b0}, // R3 no effect
    '{1'b0, 2'd0, 32'h0000_0004, 32'h0,         2'd1, 2'd0, 8'h00, 32'h0000_00F3, 1'b0}, // R3 cfg
    '{1'b0, 2'd2, 32'h0000_0008, 32'h0,         2'd1, 2'd0, 8'h00, 32'h0000_0000, 1'b0}, // R3 status
    '{1'b0, 2'd0, 32'h0000_000C, 32'h0,         2'd1, 2'd0, 8'h00, 32'h0000_0000, 1'b0}, // R3 inval read
    '{1'b0, 2'd0, 32'h0000_0010, 32'h0,         2'd1, 2'd0, 8'h00, 32'h0000_0000, 1'b1}, // R4 bad read
    '{1'b1, 2'd0, 32'h0000_0004, 32'h5,         2'd1, 2'd0, 8'h00, 32'h0000_0000, 1'b1}, // R4 write ro
    '{1'b1, 2'd0, 32'h0000_00FC, 32'h5,         2'd1, 2'd0, 8'h00, 32'h0000_0000, 1'b1}, // R4 bad write
    '{1'b0, 2'd0, 32'h0000_0001, 32'h0,         2'd1, 2'd0, 8'h00, 32'h0000_0000, 1'b1}, // R4 unaligned
    '{1'b0, 2'd2, 32'h0000_0134, 32'h0,         2'd2, 2'd2, 8'h34, 32'hA11C_0234, 1'b0}, // R5 alias
    '{1'b0, 2'd1, 32'hABCD_F144, 32'h0,         2'd2, 2'd1, 8'h44, 32'hA11C_0144, 1'b0}, // R1 high bits
    '{1'b0, 2'd1, 32'h0000_02FF, 32'h0,         2'd2, 2'd0, 8'hFF, 32'hA11C_00FF, 1'b0}, // R6 cpu0
    '{1'b0, 2'd0, 32'h0000_0408, 32'h0,         2'd2, 2'd2, 8'h08, 32'hA11C_0208, 1'b0}, // R6 cpu2
    '{1'b0, 2'd0, 32'h0000_0500, 32'h0,         2'd0, 2'd0, 8'h00, 32'h0000_0000, 1'b0}, // R9 cpu3 absent
    '{1'b0, 2'd1, 32'h0000_062C, 32'h0,         2'd3, 2'd0, 8'h3C, 32'hB7E0_003C, 1'b0}, // R7 watchdog
    '{1'b0, 2'd2, 32'h0000_0604, 32'h0,         2'd3, 2'd0, 8'h44, 32'hB7E0_0044, 1'b0}, // R7 timer
    '{1'b0, 2'd0, 32'h0000_0724, 32'h0,         2'd3, 2'd0, 8'h14, 32'hB7E0_0014, 1'b0}, // R8 cpu0 wdog
    '{1'b0, 2'd0, 32'h0000_091F, 32'h0,         2'd3, 2'd0, 8'h4F, 32'hB7E0_004F, 1'b0}, // R8 cpu2 timer
    '{1'b0, 2'd0, 32'h0000_0A20, 32'h0,         2'd0, 2'd0, 8'h00, 32'h0000_0000, 1'b0}, // R9 cpu3 absent
    '{1'b0, 2'd0, 32'h0000_0B00, 32'h0,         2'd0, 2'd0, 8'h00, 32'h0000_0000, 1'b0}, // R9 low edge
    '{1'b0, 2'd0, 32'h0000_0FFC, 32'h0,         2'd0, 2'd0, 8'h00, 32'h0000_0000, 1'b0}, // R9 top
    '{1'b1, 2'd0, 32'h0000_0C00, 32'h1,         2'd0, 2'd0, 8'h00, 32'h0000_0000, 1'b0}, // R9 write
    '{1'b1, 2'd0, 32'h0000_0000, 32'hFFFF_FFFE, 2'd1, 2'd0, 8'h00, 32'h0000_0000, 1'b0}, // R2 clear
    '{1'b0, 2'd0, 32'h0000_0000, 32'h0,         2'd1, 2'd0, 8'h00, 32'h0000_0000, 1'b0}, // R2 read 0
    '{1'b0, 2'd0, 32'h1234_5004, 32'h0,         2'd1, 2'd0, 8'h00, 32'h0000_00F3, 1'b0}  // R1 alias cfg
  };

  // drive at negedge, check selects 1 ns later, response at the following negedge
  task automatic run_vec(input vec_t v);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = v.wr; req_addr_i = v.addr;
    req_wdata_i = v.wdata; req_cpu_i = v.cpu;
    #1;
    chk(gic_sel_o == (v.sel == 2'd2), "R5/R6/R9 gic_sel", gic_sel_o, v.sel);
    chk(tmr_sel_o == (v.sel == 2'd3), "R7/R8/R9 tmr_sel", tmr_sel_o, v.sel);
    if (v.sel == 2'd2)
      chk({gic_cpu_o, gic_off_o} == {v.tcpu, v.loc}, "R5/R6 gic route", {gic_cpu_o, gic_off_o}, {v.tcpu, v.loc});
    if (v.sel == 2'd3)
      chk({1'b0, tmr_idx_o, tmr_off_o} == v.loc, "R7/R8 tmr route", {tmr_idx_o, tmr_off_o}, v.loc);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(rsp_valid_o, "R10 valid", rsp_valid_o, 1);
    chk(rsp_rdata_o == v.rdata, "R10 rdata", rsp_rdata_o, v.rdata);
    chk(rsp_err_o == v.err, "R4 err", rsp_err_o, v.err);
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [32*NCPU-1:0] exp_ppi;
    #5;
    chk(rsp_valid_o == 1'b0 && rsp_err_o == 1'b0, "R12 reset rsp", {rsp_valid_o, rsp_err_o}, 0);
    chk(rsp_rdata_o == '0, "R12 reset rdata", rsp_rdata_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10: idle cycle produces no response, then back-to-back reads
    @(negedge clk_i);
    chk(!rsp_valid_o, "R10 idle", rsp_valid_o, 0);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_cpu_i = 2'd1; req_addr_i = 32'h004;
    @(negedge clk_i);
    chk(rsp_valid_o && rsp_rdata_o == 32'hF3, "R10 b2b first", rsp_rdata_o, 32'hF3);
    req_addr_i = 32'h134;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(rsp_valid_o && rsp_rdata_o == 32'hA11C_0134, "R10 b2b second", rsp_rdata_o, 32'hA11C_0134);

    // R11: interrupt routing for two patterns
    foreach (tmr_irq_i[k]) ;
    for (int p = 0; p < 2; p++) begin
      tmr_irq_i = (p == 0) ? 6'b100101 : 6'b011010;
      exp_ppi = '0;
      for (int c = 0; c < NCPU; c++) begin
        exp_ppi[c*32+29] = tmr_irq_i[2*c];
        exp_ppi[c*32+30] = tmr_irq_i[2*c+1];
      end
      #1;
      chk(ppi_o == exp_ppi, "R11 ppi", ppi_o, exp_ppi);
    end

    // R12: set control bit, reset mid-run, read back cleared
    run_vec('{1'b1, 2'd0, 32'h0, 32'h1, 2'd1, 2'd0, 8'h00, 32'h0, 1'b0});
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    chk(!rsp_valid_o, "R12 async reset", rsp_valid_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    run_vec('{1'b0, 2'd0, 32'h0, 32'h0, 2'd1, 2'd0, 8'h00, 32'h0, 1'b0}); // R12 ctrl cleared

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule